// File: doc/BRIEF.md
# Presettable Up/Down Binary Counter

A small binary counter that steps up or down by one on each rising clock edge while its active-low count enable is asserted. A single direction line picks the count direction. An active-low parallel load takes over from the clock. As soon as it falls, the visible count shows the data inputs. While it stays low, every clock edge keeps reloading the data. Counting continues from the loaded value on the first rising edge after load is released. Loading a chosen start value turns the block into a modulo-N divider.

Two cascade outputs help chain several counters. The limit flag is high while the count sits at the terminal value for the present direction: all ones when counting up, zero when counting down. The active-low ripple output repeats that condition, but only during the low half of the clock and only while counting is enabled. This gives one clean pulse that a following stage can use as its enable or its clock.

Top module: `updn_counter`

## Requirements
- R1: While rst_ni is low, count_o is 0, at_limit_o is 0 when down_i is 0, and ripple_no is 1.
- R2: With load_ni high, en_ni low and down_i low (up), each rising clock edge adds one to count_o, and 15 wraps to 0.
- R3: With load_ni high, en_ni low and down_i high (down), each rising clock edge subtracts one from count_o, and 0 wraps to 15.
- R4: With load_ni high and en_ni high, rising clock edges leave count_o unchanged.
- R5: While load_ni is low, count_o equals data_i without waiting for a clock edge, and rising edges do not count. After load_ni returns high, counting starts from the value held at the last rising edge (or at the falling edge of load_ni if no edge came in between).
- R6: at_limit_o is 1 exactly when count_o is 15 with down_i low, or when count_o is 0 with down_i high. Otherwise it is 0.
- R7: ripple_no is 0 only while clk_i is low, at_limit_o is 1 and en_ni is low. At all other times it is 1.
- R8: Loading 13 and then counting gives 14, 15, 0, 1, 2 going up. The count holds at 2 while inhibited, and then gives 1, 0, 15, 14, 13 going down.
- R9: Changes on en_ni and down_i between clock edges leave count_o unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low, clears the count |
| en_ni | input | 1 | Count enable, active low |
| down_i | input | 1 | Direction: 0 counts up, 1 counts down |
| load_ni | input | 1 | Asynchronous parallel load, active low |
| data_i | input | 4 | Parallel preset value |
| count_o | output | 4 | Present count |
| at_limit_o | output | 1 | High at the terminal count for the present direction |
| ripple_no | output | 1 | Low pulse at the terminal count during the low clock phase |

## Verification
Count steps appear on count_o in the same cycle as the rising edge that causes them, with no pipeline register. The bench therefore drives inputs on the falling edge and checks the count 5 ns after the next rising edge. Load, the limit flag and the ripple output are combinational, so they are checked 5 ns after the input change in the same half period. Each one is checked in both clock phases, so the ripple output is seen idle while the clock is high and active only while it is low. The reference model updates only at rising edges, or at once when load is low. This follows the zero-latency timing above.

// File: rtl/updn_pkg.sv
package updn_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/updn_state.sv
module updn_state #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic         down_i,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o
);
  import updn_pkg::*;

  logic [W-1:0] q;
  dir_e         dir;

  assign dir = dir_e'(down_i);

  // load falls asynchronously; reset wins over load
  always_ff @(posedge clk_i or negedge rst_ni or negedge load_ni) begin
    if (!rst_ni)       q <= '0;
    else if (!load_ni) q <= data_i;
    else if (!en_ni)   q <= (dir == DIR_DOWN) ? q - 1'b1 : q + 1'b1;
  end

  // transparent while load is held low
  assign count_o = load_ni ? q : data_i;

  a_r4_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && en_ni) |=> (!load_ni || $stable(count_o)));

  a_r2_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_ni && !down_i) |=> (!load_ni || count_o == $past(count_o) + 1'b1));

  a_r3_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_ni && down_i) |=> (!load_ni || count_o == $past(count_o) - 1'b1));
endmodule

// File: rtl/updn_cascade.sv
module updn_cascade #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic         down_i,
  input  logic [W-1:0] count_i,
  output logic         at_limit_o,
  output logic         ripple_no
);
  import updn_pkg::*;

  localparam logic [W-1:0] TOP = {W{1'b1}};

  dir_e dir;
  assign dir = dir_e'(down_i);

  always_comb begin
    if (dir == DIR_DOWN) at_limit_o = (count_i == '0);
    else                 at_limit_o = (count_i == TOP);
  end

  // pulse only in the low clock phase of an enabled terminal count
  assign ripple_no = ~(at_limit_o & ~en_ni & ~clk_i);

  a_r7_idle_high_phase: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ripple_no);

  a_r7_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ripple_no |-> (at_limit_o && !en_ni));
endmodule

// File: rtl/updn_counter.sv
module updn_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic         down_i,
  input  logic         load_ni,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] count_o,
  output logic         at_limit_o,
  output logic         ripple_no
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  updn_state #(.W(W)) u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_ni   (en_ni),
    .down_i  (down_i),
    .load_ni (load_ni),
    .data_i  (data_i),
    .count_o (count_o)
  );

  updn_cascade #(.W(W)) u_cascade (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_ni      (en_ni),
    .down_i     (down_i),
    .count_i    (count_o),
    .at_limit_o (at_limit_o),
    .ripple_no  (ripple_no)
  );

  a_r2_wrap_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_ni && !down_i && count_o == TOP) |=> (!load_ni || count_o == '0));

  a_r3_wrap_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_ni && !en_ni && down_i && count_o == '0) |=> (!load_ni || count_o == TOP));

  a_r6_limit_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!down_i && at_limit_o) |-> (count_o == TOP));
endmodule

// File: tb/updn_counter_bench.sv
`timescale 1ns/1ps
module updn_counter_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_ni = 1'b1;
  logic       down_i = 1'b0;
  logic       load_ni = 1'b1;
  logic [3:0] data_i = 4'd0;
  logic [3:0] count_o;
  logic       at_limit_o;
  logic       ripple_no;

  int total = 0;
  int bad = 0;
  logic [3:0] mq = 4'd0;

  always #10 clk_i = ~clk_i;

  updn_counter u_updn_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_ni      (en_ni),
    .down_i     (down_i),
    .load_ni    (load_ni),
    .data_i     (data_i),
    .count_o    (count_o),
    .at_limit_o (at_limit_o),
    .ripple_no  (ripple_no)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit lim(logic [3:0] c, bit d);
    return d ? (c == 4'd0) : (c == 4'd15);
  endfunction

  task automatic step(bit l, bit e, bit d, logic [3:0] dat);
    logic [3:0] ec;
    @(negedge clk_i);
    load_ni = l; en_ni = e; down_i = d; data_i = dat;
    if (!l) mq = dat;
    #5;
    ec = l ? mq : dat;
    chk(l ? "R9 count before edge" : "R5 load follows data", count_o, ec);
    chk("R6 limit low phase", at_limit_o, lim(ec, d));
    chk("R7 ripple low phase", ripple_no, !(lim(ec, d) && !e));
    @(posedge clk_i);
    if (!l)      mq = dat;
    else if (!e) mq = d ? mq - 4'd1 : mq + 4'd1;
    #5;
    ec = l ? mq : dat;
    if (!l)      chk("R5 edge under load", count_o, ec);
    else if (e)  chk("R4 hold", count_o, ec);
    else if (d)  chk("R3 count down", count_o, ec);
    else         chk("R2 count up", count_o, ec);
    chk("R6 limit high phase", at_limit_o, lim(ec, d));
    chk("R7 ripple high phase", ripple_no, 1);
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 13;
    void'($urandom(seed));
    #15;
    chk("R1 reset count", count_o, 0);
    chk("R1 reset limit", at_limit_o, 0);
    chk("R1 reset ripple", ripple_no, 1);
    #20;
    chk("R1 reset ripple low phase", ripple_no, 1);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R8 reference sequence
    step(0, 1, 0, 4'd13); chk("R8 load 13", count_o, 13);
    begin
      int up_seq[5] = '{14, 15, 0, 1, 2};
      int dn_seq[5] = '{1, 0, 15, 14, 13};
      foreach (up_seq[i]) begin
        step(1, 0, 0, 4'd5); chk("R8 up", count_o, up_seq[i]);
      end
      step(1, 1, 0, 4'd5); chk("R8 inhibit", count_o, 2);
      foreach (dn_seq[i]) begin
        step(1, 0, 1, 4'd5); chk("R8 down", count_o, dn_seq[i]);
      end
    end

    // R5 load held across enabled edges, data changing under it
    step(0, 0, 0, 4'd7);
    step(0, 0, 0, 4'd9);
    step(0, 0, 1, 4'd0);
    step(1, 0, 1, 4'd3); chk("R5 resume from loaded", count_o, 15);
    // R7 enabled terminal count both ways, then disabled terminal count
    step(0, 1, 0, 4'd15);
    step(1, 1, 0, 4'd0);
    step(1, 0, 0, 4'd0);
    step(1, 1, 1, 4'd0);

    for (int n = 0; n < 400; n++) begin
      bit l = ($urandom % 6) != 0;
      bit e = ($urandom % 4) == 0;
      bit d = $urandom % 2;
      step(l, e, d, 4'($urandom));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule